// File: doc/BRIEF.md
# SCSI Host Adapter Interrupt and Status Registers

This block keeps the interrupt-cause, status and sequence-step registers of a simple SCSI host adapter, together with a FIFO-flags register and the first configuration register. It drives one level-sensitive interrupt line. The host reaches the registers through byte-wide reads and writes at a register index. The command decoder supplies a command byte, and the datapath reports completion events: selection finished, selection of an absent target, data transfer finished, and status phase finished.

Each command or event loads its own preset mix of cause bits, status bits and sequence step, and may raise the interrupt. Reading the interrupt-cause register is destructive. The read returns the current cause and, on the same clock edge, clears the cause, clears terminal count, sets the step to command-done and lowers the interrupt. The block does not model bus phases, DMA memory traffic or FIFO data.

Register indices: 0 status, 1 interrupt cause, 2 sequence step, 3 FIFO flags, 4 configuration 1; any other index reads 0. Status layout: bit 7 interrupt pending, bit 4 terminal count, bits 2:0 phase. Cause layout: bit 7 bus reset seen, bit 5 disconnect, bit 4 bus service, bit 3 function complete. The command-done step code is 4.

Top module: `scsi_irq_status`

## Requirements
- R1: The interrupt line and status bit 7 are set together by a raise and cleared together by a lower. A second raise while pending changes neither of them.
- R2: `rdata` at index 1 shows the current cause. A read strobe there leaves, after the edge, cause 0x00, step 4, status bit 4 clear and the interrupt low.
- R3: Command opcode 0x03 (bus reset) loads cause 0x80. It raises the interrupt only when configuration 1 bit 6 is 0; when that bit is 1 the line keeps its level.
- R4: The absent-target event zeroes status bits 6:0, loads cause 0x20 and step 0, and raises the interrupt.
- R5: The selection-done event loads status bits 6:0 with 0x10, cause 0x18 and step 4, and raises the interrupt.
- R6: Opcode 0x01 (flush) loads cause 0x08 and zeroes the step and the FIFO flags. It leaves the interrupt line and the status register as they were.
- R7: Opcode 0x12 (message accepted) loads cause 0x20 and zeroes the step and the FIFO flags, then raises the interrupt.
- R8: Opcode 0x02, the `ext_rst` level, or `rst` clears the status, cause, step and flags registers, lowers the interrupt and sets configuration 1 to 0x07.
- R9: Opcode 0x45 clears the cause and raises the interrupt. Opcode 0x44 clears the cause and leaves the interrupt alone.
- R10: The opcode is command bits 6:0, and bit 7 is a DMA flag that does not change the decode. Opcode 0x00 and any opcode not listed in R3, R6 to R9 or R8 change no register.
- R11: The transfer-done event sets status bit 4 and keeps the other status bits. The status-done event loads status bits 6:0 with 0x13. Both events load cause 0x10, step 0 and flags 0, and raise the interrupt.
- R12: When several sources act in one cycle, the winner follows this order: command, absent target, selection done, status done, transfer done, interrupt-cause read. Losing sources have no effect, so a cause read that loses is not destructive.
- R13: Host writes load configuration 1 (index 4) and the FIFO flags (index 3). Writes to indices 0, 1 and 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ext_rst | input | 1 | External reset level, synchronous |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_idx | input | IDX_W | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx`, combinational |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Bit 7 DMA flag, bits 6:0 opcode |
| ev_sel_miss | input | 1 | Selection of an absent target |
| ev_sel_ok | input | 1 | Selection completed |
| ev_stat_done | input | 1 | Status phase completed |
| ev_xfer_done | input | 1 | Data transfer completed |
| irq | output | 1 | Level interrupt, polarity set by IRQ_ACTIVE_LOW |

## Verification
The assertions run on every cycle. They check that the interrupt-pending bit follows the raise and lower requests, and that a winning cause read always leaves cause 0, step 4 and terminal count clear. They also check that a suppressed bus reset and a flush hold the line steady, that any reset restores configuration 1, that unknown opcodes freeze the registers, and that the arbiter lets a command win. The exact cause, status and step values for each command and event can only be shown by the bench scenarios. The same holds for the non-destructive read that loses arbitration and for the ignored writes, which the bench reads back through `reg_rdata`.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;

   typedef enum logic [3:0] {
      ACT_NONE, ACT_NOP, ACT_FLUSH, ACT_RESET, ACT_BUSRST, ACT_MSGACC,
      ACT_ENSEL, ACT_DISSEL, ACT_SEL_MISS, ACT_SEL_OK, ACT_STAT_DONE,
      ACT_XFER_DONE, ACT_RD_INTR
   } act_e;

   localparam int OPC_W = 7;

   localparam logic [OPC_W-1:0] OPC_NOP    = 7'h00;
   localparam logic [OPC_W-1:0] OPC_FLUSH  = 7'h01;
   localparam logic [OPC_W-1:0] OPC_RESET  = 7'h02;
   localparam logic [OPC_W-1:0] OPC_BUSRST = 7'h03;
   localparam logic [OPC_W-1:0] OPC_MSGACC = 7'h12;
   localparam logic [OPC_W-1:0] OPC_ENSEL  = 7'h44;
   localparam logic [OPC_W-1:0] OPC_DISSEL = 7'h45;

   localparam logic [7:0] CAUSE_BUSRST = 8'h80;
   localparam logic [7:0] CAUSE_DISC   = 8'h20;
   localparam logic [7:0] CAUSE_SVC    = 8'h10;
   localparam logic [7:0] CAUSE_FDONE  = 8'h08;

   localparam int          ST_TC_BIT    = 4;
   localparam logic [6:0]  ST_TC        = 7'h10;
   localparam logic [6:0]  ST_STAT_PH   = 7'h03;

   localparam int RIX_STAT  = 0;
   localparam int RIX_CAUSE = 1;
   localparam int RIX_STEP  = 2;
   localparam int RIX_FLAGS = 3;
   localparam int RIX_CFG1  = 4;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
   import scsi_irq_pkg::*;
(
   input  logic             valid_i,
   input  logic [OPC_W-1:0] opcode_i,
   output act_e             act_o
);

   always_comb begin
      act_o = ACT_NONE;
      if (valid_i) begin
         unique case (opcode_i)
            OPC_NOP:    act_o = ACT_NOP;
            OPC_FLUSH:  act_o = ACT_FLUSH;
            OPC_RESET:  act_o = ACT_RESET;
            OPC_BUSRST: act_o = ACT_BUSRST;
            OPC_MSGACC: act_o = ACT_MSGACC;
            OPC_ENSEL:  act_o = ACT_ENSEL;
            OPC_DISSEL: act_o = ACT_DISSEL;
            default:    act_o = ACT_NONE;
         endcase
      end
   end

endmodule

// File: rtl/scsi_act_arbiter.sv
module scsi_act_arbiter
   import scsi_irq_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  act_e cmd_act_i,
   input  logic sel_miss_i,
   input  logic sel_ok_i,
   input  logic stat_done_i,
   input  logic xfer_done_i,
   input  logic rd_intr_i,
   output act_e act_o
);

   always_comb begin
      if (cmd_act_i != ACT_NONE) act_o = cmd_act_i;
      else if (sel_miss_i)       act_o = ACT_SEL_MISS;
      else if (sel_ok_i)         act_o = ACT_SEL_OK;
      else if (stat_done_i)      act_o = ACT_STAT_DONE;
      else if (xfer_done_i)      act_o = ACT_XFER_DONE;
      else if (rd_intr_i)        act_o = ACT_RD_INTR;
      else                       act_o = ACT_NONE;
   end

   // R12: a command always beats every event and the read
   p_cmd_wins_r12: assert property (@(posedge clk) disable iff (rst)
      (cmd_act_i != ACT_NONE) |-> (act_o == cmd_act_i));

   // R12: a read loses whenever any event is present
   p_event_beats_read_r12: assert property (@(posedge clk) disable iff (rst)
      (rd_intr_i && (sel_miss_i || sel_ok_i || stat_done_i || xfer_done_i))
      |-> (act_o != ACT_RD_INTR));

endmodule

// File: rtl/scsi_irq_line.sv
module scsi_irq_line #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic raise_i,
   input  logic lower_i,
   output logic pend_o,
   output logic line_o
);

   logic pend_q;
   logic drive_q;

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         pend_q  <= 1'b0;
         drive_q <= 1'b0;
      end else if (raise_i && !pend_q) begin
         pend_q  <= 1'b1;
         drive_q <= 1'b1;
      end else if (lower_i && pend_q) begin
         pend_q  <= 1'b0;
         drive_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   generate
      if (ACTIVE_LOW) begin : g_low
         assign line_o = ~drive_q;
      end else begin : g_high
         assign line_o = drive_q;
      end
   endgenerate

   p_raise_sets_r1: assert property (@(posedge clk) disable iff (rst)
      (raise_i && !clr_i) |=> pend_o);

   p_lower_clears_r2: assert property (@(posedge clk) disable iff (rst)
      (lower_i && !raise_i && !clr_i) |=> !pend_o);

   p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
      (!raise_i && !lower_i && !clr_i) |=> $stable(pend_o));

   p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (!pend_o && (line_o == ACTIVE_LOW)));

endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
   import scsi_irq_pkg::*;
#(
   parameter int         IDX_W          = 3,
   parameter int         STEP_W         = 3,
   parameter int         STEP_DONE      = 4,
   parameter int         SUPPRESS_BIT   = 6,
   parameter logic [7:0] CFG1_INIT      = 8'h07,
   parameter bit         IRQ_ACTIVE_LOW = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ext_rst,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [IDX_W-1:0] reg_idx,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             cmd_valid,
   input  logic [7:0]       cmd_byte,
   input  logic             ev_sel_miss,
   input  logic             ev_sel_ok,
   input  logic             ev_stat_done,
   input  logic             ev_xfer_done,
   output logic             irq
);

   localparam logic [STEP_W-1:0] STEP_CD   = STEP_W'(STEP_DONE);
   localparam logic [IDX_W-1:0]  IX_STAT   = IDX_W'(RIX_STAT);
   localparam logic [IDX_W-1:0]  IX_CAUSE  = IDX_W'(RIX_CAUSE);
   localparam logic [IDX_W-1:0]  IX_STEP   = IDX_W'(RIX_STEP);
   localparam logic [IDX_W-1:0]  IX_FLAGS  = IDX_W'(RIX_FLAGS);
   localparam logic [IDX_W-1:0]  IX_CFG1   = IDX_W'(RIX_CFG1);

   initial begin
      assert (IDX_W >= 3) else $error("IDX_W too small for five registers");
      assert (STEP_W >= 1 && STEP_W <= 8) else $error("STEP_W out of range");
      assert (STEP_DONE < (1 << STEP_W)) else $error("STEP_DONE does not fit");
      assert (SUPPRESS_BIT < 8) else $error("SUPPRESS_BIT outside byte");
   end

   logic [6:0]        stat_lo_q;
   logic [7:0]        cause_q;
   logic [STEP_W-1:0] step_q;
   logic [7:0]        flags_q;
   logic [7:0]        cfg1_q;

   act_e dec_act;
   act_e act;
   logic rd_intr;
   logic hard_clr;
   logic irq_clr;
   logic raise;
   logic lower;
   logic irq_pend;

   assign rd_intr = reg_rd && (reg_idx == IX_CAUSE);

   scsi_cmd_decode u_dec (
      .valid_i  (cmd_valid),
      .opcode_i (cmd_byte[OPC_W-1:0]),
      .act_o    (dec_act)
   );

   scsi_act_arbiter u_arb (
      .clk         (clk),
      .rst         (rst),
      .cmd_act_i   (dec_act),
      .sel_miss_i  (ev_sel_miss),
      .sel_ok_i    (ev_sel_ok),
      .stat_done_i (ev_stat_done),
      .xfer_done_i (ev_xfer_done),
      .rd_intr_i   (rd_intr),
      .act_o       (act)
   );

   assign irq_clr  = ext_rst || (act == ACT_RESET);
   assign hard_clr = rst || irq_clr;

   always_comb begin
      unique case (act)
         ACT_BUSRST:    raise = !cfg1_q[SUPPRESS_BIT];
         ACT_MSGACC,
         ACT_DISSEL,
         ACT_SEL_MISS,
         ACT_SEL_OK,
         ACT_STAT_DONE,
         ACT_XFER_DONE: raise = 1'b1;
         default:       raise = 1'b0;
      endcase
   end

   assign lower = (act == ACT_RD_INTR);

   scsi_irq_line #(.ACTIVE_LOW(IRQ_ACTIVE_LOW)) u_line (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (irq_clr),
      .raise_i (raise),
      .lower_i (lower),
      .pend_o  (irq_pend),
      .line_o  (irq)
   );

   always_ff @(posedge clk) begin
      if (hard_clr) begin
         stat_lo_q <= '0;
         cause_q   <= '0;
         step_q    <= '0;
         flags_q   <= '0;
         cfg1_q    <= CFG1_INIT;
      end else begin
         if (reg_wr) begin
            if (reg_idx == IX_CFG1)  cfg1_q  <= reg_wdata;
            if (reg_idx == IX_FLAGS) flags_q <= reg_wdata;
         end
         unique case (act)
            ACT_FLUSH: begin
               cause_q <= CAUSE_FDONE;
               step_q  <= '0;
               flags_q <= '0;
            end
            ACT_BUSRST:  cause_q <= CAUSE_BUSRST;
            ACT_MSGACC: begin
               cause_q <= CAUSE_DISC;
               step_q  <= '0;
               flags_q <= '0;
            end
            ACT_ENSEL,
            ACT_DISSEL:  cause_q <= '0;
            ACT_SEL_MISS: begin
               stat_lo_q <= '0;
               cause_q   <= CAUSE_DISC;
               step_q    <= '0;
            end
            ACT_SEL_OK: begin
               stat_lo_q <= ST_TC;
               cause_q   <= CAUSE_SVC | CAUSE_FDONE;
               step_q    <= STEP_CD;
            end
            ACT_STAT_DONE: begin
               stat_lo_q <= ST_TC | ST_STAT_PH;
               cause_q   <= CAUSE_SVC;
               step_q    <= '0;
               flags_q   <= '0;
            end
            ACT_XFER_DONE: begin
               stat_lo_q <= stat_lo_q | ST_TC;
               cause_q   <= CAUSE_SVC;
               step_q    <= '0;
               flags_q   <= '0;
            end
            ACT_RD_INTR: begin
               cause_q              <= '0;
               stat_lo_q[ST_TC_BIT] <= 1'b0;
               step_q               <= STEP_CD;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (reg_idx)
         IX_STAT:  reg_rdata = {irq_pend, stat_lo_q};
         IX_CAUSE: reg_rdata = cause_q;
         IX_STEP:  reg_rdata = 8'(step_q);
         IX_FLAGS: reg_rdata = flags_q;
         IX_CFG1:  reg_rdata = cfg1_q;
         default:  reg_rdata = 8'h00;
      endcase
   end

   p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_RD_INTR && !ext_rst) |=>
      (cause_q == 8'h00 && step_q == STEP_CD && !stat_lo_q[ST_TC_BIT] && !irq_pend));

   p_busrst_quiet_r3: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_BUSRST && cfg1_q[SUPPRESS_BIT] && !ext_rst) |=>
      ($stable(irq_pend) && cause_q == CAUSE_BUSRST));

   p_flush_no_raise_r6: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_FLUSH && !ext_rst) |=>
      ($stable(irq_pend) && cause_q == CAUSE_FDONE && flags_q == 8'h00));

   p_reset_cfg_r8: assert property (@(posedge clk) disable iff (rst)
      hard_clr |=> (cfg1_q == CFG1_INIT && !irq_pend && cause_q == 8'h00));

   p_unknown_frozen_r10: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_NONE && !reg_wr && !ext_rst) |=>
      ($stable(cause_q) && $stable(step_q) && $stable(stat_lo_q) &&
       $stable(flags_q) && $stable(cfg1_q) && $stable(irq_pend)));

endmodule

// File: tb/scsi_irq_status_test.sv
module scsi_irq_status_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       ext_rst;
   logic       reg_wr;
   logic       reg_rd;
   logic [2:0] reg_idx;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic       cmd_valid;
   logic [7:0] cmd_byte;
   logic       ev_sel_miss;
   logic       ev_sel_ok;
   logic       ev_stat_done;
   logic       ev_xfer_done;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scsi_irq_status uut (
      .clk          (clk),
      .rst          (rst),
      .ext_rst      (ext_rst),
      .reg_wr       (reg_wr),
      .reg_rd       (reg_rd),
      .reg_idx      (reg_idx),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .cmd_valid    (cmd_valid),
      .cmd_byte     (cmd_byte),
      .ev_sel_miss  (ev_sel_miss),
      .ev_sel_ok    (ev_sel_ok),
      .ev_stat_done (ev_stat_done),
      .ev_xfer_done (ev_xfer_done),
      .irq          (irq)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] peek(input int idx);
      return 8'h00;
   endfunction

   task automatic look(input logic [2:0] idx, output logic [7:0] v);
      reg_idx = idx;
      #1;
      v = reg_rdata;
   endtask

   task automatic chk_reg(input string tag, input logic [2:0] idx, input logic [7:0] exp);
      logic [7:0] v;
      look(idx, v);
      chk(tag, v, exp);
   endtask

   task automatic chk_irq(input string tag, input logic exp);
      chk(tag, {7'b0, irq}, {7'b0, exp});
   endtask

   task automatic cmd(input logic [7:0] b);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = b;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_byte  = 8'h00;
   endtask

   task automatic wr(input logic [2:0] idx, input logic [7:0] d);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_idx   = idx;
      reg_wdata = d;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd_cause(output logic [7:0] v);
      @(negedge clk);
      reg_rd  = 1'b1;
      reg_idx = 3'd1;
      #1;
      v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic miss, input logic ok, input logic st, input logic xf);
      @(negedge clk);
      ev_sel_miss  = miss;
      ev_sel_ok    = ok;
      ev_stat_done = st;
      ev_xfer_done = xf;
      @(negedge clk);
      ev_sel_miss  = 1'b0;
      ev_sel_ok    = 1'b0;
      ev_stat_done = 1'b0;
      ev_xfer_done = 1'b0;
   endtask

   task automatic t_reset_state();
      chk_reg("R8 reset status", 3'd0, 8'h00);
      chk_reg("R8 reset cause", 3'd1, 8'h00);
      chk_reg("R8 reset step", 3'd2, 8'h00);
      chk_reg("R8 reset flags", 3'd3, 8'h00);
      chk_reg("R8 reset cfg1", 3'd4, 8'h07);
      chk_irq("R8 reset irq", 1'b0);
   endtask

   task automatic t_bus_reset();
      logic [7:0] v;
      cmd(8'h03);
      chk_reg("R3 busrst cause", 3'd1, 8'h80);
      chk_irq("R3 busrst raise", 1'b1);
      chk_reg("R1 pending bit", 3'd0, 8'h80);
      rd_cause(v);
      chk("R2 read returns old", v, 8'h80);
      chk_reg("R2 cause cleared", 3'd1, 8'h00);
      chk_reg("R2 step done", 3'd2, 8'h04);
      chk_reg("R2 status cleared", 3'd0, 8'h00);
      chk_irq("R2 irq lowered", 1'b0);
      wr(3'd4, 8'h47);
      cmd(8'h83);
      chk_reg("R3 suppressed cause", 3'd1, 8'h80);
      chk_irq("R3 suppressed no raise", 1'b0);
      rd_cause(v);
      wr(3'd4, 8'h07);
   endtask

   task automatic t_line();
      logic [7:0] v;
      cmd(8'h45);
      chk_irq("R1 first raise", 1'b1);
      cmd(8'h45);
      chk_irq("R1 second raise", 1'b1);
      chk_reg("R1 pending held", 3'd0, 8'h80);
      rd_cause(v);
      chk_irq("R1 single lower", 1'b0);
      chk_reg("R1 pending gone", 3'd0, 8'h00);
   endtask

   task automatic t_xfer_miss();
      logic [7:0] v;
      wr(3'd3, 8'h05);
      pulse(1'b0, 1'b0, 1'b0, 1'b1);
      chk_reg("R11 xfer status", 3'd0, 8'h90);
      chk_reg("R11 xfer cause", 3'd1, 8'h10);
      chk_reg("R11 xfer step", 3'd2, 8'h00);
      chk_reg("R11 xfer flags", 3'd3, 8'h00);
      chk_irq("R11 xfer irq", 1'b1);
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      chk_reg("R4 miss status", 3'd0, 8'h80);
      chk_reg("R4 miss cause", 3'd1, 8'h20);
      chk_reg("R4 miss step", 3'd2, 8'h00);
      chk_irq("R4 miss irq", 1'b1);
      rd_cause(v);
      chk("R4 miss read", v, 8'h20);
   endtask

   task automatic t_sel_ok();
      logic [7:0] v;
      pulse(1'b0, 1'b1, 1'b0, 1'b0);
      chk_reg("R5 selok status", 3'd0, 8'h90);
      chk_reg("R5 selok cause", 3'd1, 8'h18);
      chk_reg("R5 selok step", 3'd2, 8'h04);
      chk_irq("R5 selok irq", 1'b1);
      rd_cause(v);
      chk("R5 selok read", v, 8'h18);
      chk_reg("R2 tc cleared", 3'd0, 8'h00);
   endtask

   task automatic t_stat_done();
      logic [7:0] v;
      pulse(1'b0, 1'b0, 1'b1, 1'b0);
      chk_reg("R11 stat status", 3'd0, 8'h93);
      chk_reg("R11 stat cause", 3'd1, 8'h10);
      chk_reg("R11 stat step", 3'd2, 8'h00);
      chk_irq("R11 stat irq", 1'b1);
      rd_cause(v);
      chk_reg("R2 phase kept tc cleared", 3'd0, 8'h03);
   endtask

   task automatic t_flush();
      logic [7:0] v;
      wr(3'd3, 8'h06);
      cmd(8'h81);
      chk_reg("R6 flush cause", 3'd1, 8'h08);
      chk_reg("R6 flush step", 3'd2, 8'h00);
      chk_reg("R6 flush flags", 3'd3, 8'h00);
      chk_reg("R6 flush status", 3'd0, 8'h03);
      chk_irq("R6 flush no raise", 1'b0);
      cmd(8'h45);
      cmd(8'h01);
      chk_irq("R6 flush keeps line", 1'b1);
      rd_cause(v);
      chk("R6 flush read", v, 8'h08);
   endtask

   task automatic t_msgacc();
      logic [7:0] v;
      wr(3'd3, 8'h09);
      cmd(8'h12);
      chk_reg("R7 msgacc cause", 3'd1, 8'h20);
      chk_reg("R7 msgacc step", 3'd2, 8'h00);
      chk_reg("R7 msgacc flags", 3'd3, 8'h00);
      chk_irq("R7 msgacc irq", 1'b1);
      rd_cause(v);
   endtask

   task automatic t_selection_enable();
      logic [7:0] v;
      cmd(8'h01);
      cmd(8'h44);
      chk_reg("R9 ensel cause", 3'd1, 8'h00);
      chk_irq("R9 ensel no raise", 1'b0);
      cmd(8'h01);
      cmd(8'h45);
      chk_reg("R9 dissel cause", 3'd1, 8'h00);
      chk_irq("R9 dissel raise", 1'b1);
      rd_cause(v);
   endtask

   task automatic t_unknown();
      logic [7:0] st;
      cmd(8'h01);
      wr(3'd3, 8'h03);
      look(3'd0, st);
      cmd(8'h7F);
      cmd(8'h20);
      cmd(8'hA0);
      cmd(8'h80);
      chk_reg("R10 cause kept", 3'd1, 8'h08);
      chk_reg("R10 flags kept", 3'd3, 8'h03);
      chk_reg("R10 step kept", 3'd2, 8'h00);
      chk_reg("R10 status kept", 3'd0, st);
      chk_reg("R10 cfg1 kept", 3'd4, 8'h07);
      chk_irq("R10 irq kept", 1'b0);
   endtask

   task automatic t_priority();
      logic [7:0] v;
      @(negedge clk);
      reg_rd       = 1'b1;
      reg_idx      = 3'd1;
      ev_xfer_done = 1'b1;
      #1;
      v = reg_rdata;
      @(negedge clk);
      reg_rd       = 1'b0;
      ev_xfer_done = 1'b0;
      chk("R12 losing read value", v, 8'h08);
      chk_reg("R12 event beats read", 3'd1, 8'h10);
      chk_irq("R12 irq raised", 1'b1);
      chk_reg("R12 status", 3'd0, 8'h93);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = 8'h01;
      ev_sel_ok = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      ev_sel_ok = 1'b0;
      chk_reg("R12 command beats event", 3'd1, 8'h08);
      chk_reg("R12 step from command", 3'd2, 8'h00);
      chk_irq("R12 irq unchanged", 1'b1);
      rd_cause(v);
   endtask

   task automatic t_writes();
      logic [7:0] st;
      look(3'd0, st);
      wr(3'd0, 8'hFF);
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'hFF);
      chk_reg("R13 status ignored", 3'd0, st);
      chk_reg("R13 cause ignored", 3'd1, 8'h00);
      chk_reg("R13 step ignored", 3'd2, 8'h04);
      wr(3'd4, 8'h15);
      chk_reg("R13 cfg1 written", 3'd4, 8'h15);
      wr(3'd3, 8'h2A);
      chk_reg("R13 flags written", 3'd3, 8'h2A);
   endtask

   task automatic t_resets();
      cmd(8'h45);
      cmd(8'h02);
      chk_reg("R8 cmd status", 3'd0, 8'h00);
      chk_reg("R8 cmd step", 3'd2, 8'h00);
      chk_reg("R8 cmd flags", 3'd3, 8'h00);
      chk_reg("R8 cmd cfg1", 3'd4, 8'h07);
      chk_irq("R8 cmd irq", 1'b0);
      wr(3'd4, 8'h41);
      wr(3'd3, 8'h11);
      cmd(8'h45);
      @(negedge clk);
      ext_rst = 1'b1;
      @(negedge clk);
      ext_rst = 1'b0;
      chk_reg("R8 ext cfg1", 3'd4, 8'h07);
      chk_reg("R8 ext flags", 3'd3, 8'h00);
      chk_reg("R8 ext cause", 3'd1, 8'h00);
      chk_irq("R8 ext irq", 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1;
      ext_rst = 1'b0;
      reg_wr = 1'b0;
      reg_rd = 1'b0;
      reg_idx = 3'd0;
      reg_wdata = 8'h00;
      cmd_valid = 1'b0;
      cmd_byte = 8'h00;
      ev_sel_miss = 1'b0;
      ev_sel_ok = 1'b0;
      ev_stat_done = 1'b0;
      ev_xfer_done = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_bus_reset();
      t_line();
      t_xfer_miss();
      t_sel_ok();
      t_stat_done();
      t_flush();
      t_msgacc();
      t_selection_enable();
      t_unknown();
      t_priority();
      t_writes();
      t_resets();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule